// File: doc/BRIEF.md
# Page-Granular Memory Access Firewall

This block guards a 128 KB on-chip SRAM. Every access that reaches the SRAM is tested against a security rule for the 4 KB page it targets. An access carries an address, an access kind, a secure flag, a privileged flag and a compartment identifier (CID). The decision is combinational on the request. A permitted access is forwarded to the memory port in the same cycle. A refused access never reaches the memory: a refused read returns zero, a refused write is dropped, and a one-cycle illegal-access flag follows.

Each of the 32 pages has one configuration word. The word holds three CID bitmaps (read, write, privileged), a secure bit, a privileged bit and an enable bit. Only the trusted configuring CID can change these words. A global control word holds a bypass that lets secure data accesses reach nonsecure pages. A secure instruction fetch from a nonsecure page stays forbidden even with the bypass set. A read-only status word records the page of the most recent refusal.

Top module: `page_firewall`

## Requirements
- R1: The page index of a request is `req_addr[16:12]`. For example, 0x1EFFF falls in page 30 and 0x1F000 falls in page 31.
- R2: After reset all stored words read back as zero. A page whose enable bit is clear follows the default rule: secure page, not privileged, with read, write and privileged bitmaps holding only the trusted CID (CID 1). A nonsecure request to such a page is refused, and so is a request from any other CID.
- R3: Configuration writes whose `cfg_cid` is not the trusted CID change no register. Configuration addresses 0 to 31 hold the page words and address 32 holds the control word. Address 33 is the read-only fault status.
- R4: A page word with its enable bit (bit 26) clear has no effect, and the page keeps the default rule. Once the bit is set, the stored word governs the page.
- R5: A nonsecure request (`req_sec`=0) to a page whose secure bit (bit 24) is set is refused.
- R6: A read (`req_kind`=0) or an execute (`req_kind`=2) needs the requester's bit in the read bitmap (bits 7:0). A write (`req_kind`=1) needs its bit in the write bitmap (bits 15:8). Bit n of a bitmap stands for CID n, and one page may grant several CIDs. Kind 3 is always refused.
- R7: An unprivileged request to a page whose privileged bit (bit 25) is set is refused. A privileged request needs the requester's bit in the privileged bitmap (bits 23:16).
- R8: A secure data request (read or write) to a nonsecure page is refused unless the bypass (control word bit 0) is set. When the bypass is set, such a request is permitted.
- R9: A secure execute request to a nonsecure page is always refused, whatever the bypass setting.
- R10: A refused request does not assert `mem_en`, and a refused read returns zero on `req_rdata`. A permitted read returns the memory data one cycle after the request.
- R11: `illegal_o` is high for exactly the one cycle after a refused request. The fault status word then reads bit 5 = 1 and bits 4:0 = the page of the latest refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Access request present |
| req_addr | input | 17 | Byte address relative to the base of the protected range |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_sec | input | 1 | Requester is in the secure world |
| req_priv | input | 1 | Requester is privileged |
| req_cid | input | 3 | Requester compartment ID |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, forced to zero for a refused read |
| req_grant | output | 1 | Request permitted (combinational) |
| illegal_o | output | 1 | One-cycle pulse after a refused request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 17 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cid | input | 3 | CID of the configuration writer |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word at `cfg_addr` (combinational) |

## Verification
Assertions check on every cycle that the memory port stays idle for a refused request, and that a nonsecure request to a secure page is never permitted. They also check that a secure fetch from a nonsecure page is never permitted, and that the bypass is the only route for secure data into nonsecure pages. They check that an untrusted configuration write leaves every rule unchanged, and that each refusal is followed by the illegal pulse with the right page captured. Only the bench scenarios can show the actual rule contents: the default rule after reset, the masking effect of the enable bit, grants to several CIDs from one bitmap, page boundaries, and data written through a permitted access and read back while a refused access is dropped.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int NCID      = 8;
  localparam int CID_W     = $clog2(NCID);
  localparam int WORD_W    = 32;
  localparam int SPARE_W   = WORD_W - 3 - 3 * NCID;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               en;
    logic               priv;
    logic               sec;
    logic [NCID-1:0]    pmap;
    logic [NCID-1:0]    wmap;
    logic [NCID-1:0]    rmap;
  } page_rule_t;
endpackage

// File: rtl/fw_reset_sync.sv
module fw_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fw_page_dec.sv
module fw_page_dec #(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 12,
  localparam int PG_W  = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PG_W-1:0]   page
);
  assign page = addr[ADDR_W-1:OFS_W];
endmodule

// File: rtl/fw_rule_bank.sv
module fw_rule_bank
  import fw_pkg::*;
#(
  parameter int NPAGES      = 32,
  parameter int TRUSTED_CID = 1,
  localparam int PG_W       = $clog2(NPAGES),
  localparam int CFG_AW     = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CID_W-1:0]  cfg_cid,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [PG_W-1:0]   req_page,
  output page_rule_t        eff_rule,
  output logic              bypass,
  input  logic              fault_vld,
  input  logic [PG_W-1:0]   fault_page
);
  localparam int CTRL_ADDR  = NPAGES;
  localparam int FAULT_ADDR = NPAGES + 1;

  logic [NPAGES-1:0][WORD_W-1:0] regs_q, regs_d;
  logic                          byp_q, byp_d;
  logic                          cfg_ok;
  page_rule_t                    stored, dflt;

  assign cfg_ok = cfg_we && (int'(cfg_addr) <= CTRL_ADDR) &&
                  (cfg_cid == CID_W'(TRUSTED_CID));

  always_comb begin
    regs_d = regs_q;
    byp_d  = byp_q;
    if (cfg_ok) begin
      if (int'(cfg_addr) < NPAGES) regs_d[cfg_addr[PG_W-1:0]] = cfg_wdata;
      else                         byp_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      byp_q  <= 1'b0;
    end else if (cfg_ok) begin
      regs_q <= regs_d;
      byp_q  <= byp_d;
    end
  end

  always_comb begin
    dflt       = '0;
    dflt.en    = 1'b1;
    dflt.sec   = 1'b1;
    dflt.rmap  = NCID'(1) << TRUSTED_CID;
    dflt.wmap  = NCID'(1) << TRUSTED_CID;
    dflt.pmap  = NCID'(1) << TRUSTED_CID;
    stored     = page_rule_t'(regs_q[req_page]);
    eff_rule   = stored.en ? stored : dflt;
  end

  assign bypass = byp_q;

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_addr) < NPAGES)        cfg_rdata = regs_q[cfg_addr[PG_W-1:0]];
    else if (int'(cfg_addr) == CTRL_ADDR)  cfg_rdata = {{(WORD_W-1){1'b0}}, byp_q};
    else if (int'(cfg_addr) == FAULT_ADDR) cfg_rdata = {{(WORD_W-PG_W-1){1'b0}}, fault_vld, fault_page};
  end

  // R3: untrusted configuration writes leave every rule untouched
  assert_cfg_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_cid != CID_W'(TRUSTED_CID)) |=> ($stable(regs_q) && $stable(byp_q)));
endmodule

// File: rtl/fw_check.sv
module fw_check
  import fw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  page_rule_t       rule,
  input  logic             bypass,
  input  logic [1:0]       kind,
  input  logic             req_sec,
  input  logic             req_priv,
  input  logic [CID_W-1:0] req_cid,
  output logic             allow
);
  logic sec_ok, map_ok, priv_ok, is_exec;

  assign is_exec = (kind == ACC_EXEC);

  always_comb begin
    if (req_sec) sec_ok = rule.sec | (bypass & ~is_exec);
    else         sec_ok = ~rule.sec;
    case (kind)
      ACC_READ, ACC_EXEC: map_ok = rule.rmap[req_cid];
      ACC_WRITE:          map_ok = rule.wmap[req_cid];
      default:            map_ok = 1'b0;
    endcase
    priv_ok = req_priv ? rule.pmap[req_cid] : ~rule.priv;
    allow   = sec_ok & map_ok & priv_ok;
  end

  // R5: nonsecure requester never reaches a secure page
  assert_ns_to_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_sec && rule.sec) |-> !allow);
  // R9: secure fetch from a nonsecure page is never allowed
  assert_sec_exec_ns_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sec && !rule.sec && is_exec) |-> !allow);
  // R8: without bypass, secure data cannot enter nonsecure pages
  assert_no_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sec && !rule.sec && !bypass) |-> !allow);
endmodule

// File: rtl/page_firewall.sv
module page_firewall
  import fw_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int OFS_W       = 12,
  parameter int TRUSTED_CID = 1,
  localparam int PG_W       = ADDR_W - OFS_W,
  localparam int NPAGES     = 1 << PG_W,
  localparam int CFG_AW     = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_sec,
  input  logic              req_priv,
  input  logic [CID_W-1:0]  req_cid,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] req_rdata,
  output logic              req_grant,
  output logic              illegal_o,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              cfg_we,
  input  logic [CID_W-1:0]  cfg_cid,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata
);
  logic            rst_sn;
  logic [PG_W-1:0] page;
  page_rule_t      eff_rule;
  logic            bypass, allow, deny;

  logic            illegal_q, illegal_d;
  logic            rdg_q, rdg_d;
  logic            fvld_q, fvld_d;
  logic [PG_W-1:0] fpage_q, fpage_d;

  fw_reset_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sn));

  fw_page_dec #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (.addr(req_addr), .page(page));

  fw_rule_bank #(.NPAGES(NPAGES), .TRUSTED_CID(TRUSTED_CID)) u_bank (
    .clk(clk), .rst_n(rst_sn), .cfg_we(cfg_we), .cfg_cid(cfg_cid),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_page(page), .eff_rule(eff_rule), .bypass(bypass),
    .fault_vld(fvld_q), .fault_page(fpage_q));

  fw_check u_chk (
    .clk(clk), .rst_n(rst_sn), .rule(eff_rule), .bypass(bypass),
    .kind(req_kind), .req_sec(req_sec), .req_priv(req_priv),
    .req_cid(req_cid), .allow(allow));

  assign req_grant = req_valid & allow;
  assign deny      = req_valid & ~allow;
  assign mem_en    = req_grant;
  assign mem_we    = req_grant & (req_kind == ACC_WRITE);
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign req_rdata = rdg_q ? mem_rdata : '0;

  always_comb begin
    illegal_d = deny;
    rdg_d     = req_grant & (req_kind != ACC_WRITE);
    fvld_d    = fvld_q | deny;
    fpage_d   = deny ? page : fpage_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      illegal_q <= 1'b0;
      rdg_q     <= 1'b0;
      fvld_q    <= 1'b0;
      fpage_q   <= '0;
    end else begin
      illegal_q <= illegal_d;
      rdg_q     <= rdg_d;
      fvld_q    <= fvld_d;
      fpage_q   <= fpage_d;
    end
  end

  assign illegal_o = illegal_q;

  // R10: a refused request never touches the memory
  assert_deny_blocks_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_grant |-> (!mem_en && !mem_we));
  // R11: a refusal raises the illegal pulse and captures its page
  assert_illegal_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && !req_grant) |=> (illegal_o && fvld_q && fpage_q == $past(page)));
  // R11: no pulse without a refusal in the prior cycle
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    !(req_valid && !req_grant) |=> !illegal_o);
endmodule

// File: tb/tb_page_firewall.sv
`timescale 1ns/1ps
module tb_page_firewall;
  logic        clk, rst_n;
  logic        req_valid, req_sec, req_priv;
  logic [16:0] req_addr;
  logic [1:0]  req_kind;
  logic [2:0]  req_cid;
  logic [31:0] req_wdata, req_rdata;
  logic        req_grant, illegal_o, mem_en, mem_we;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        cfg_we;
  logic [2:0]  cfg_cid;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;

  int checks = 0;
  int errors = 0;

  page_firewall dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] mem [0:511];
  function automatic int midx(input logic [16:0] a);
    return {a[16:12], a[5:2]};
  endfunction
  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[midx(mem_addr)] <= mem_wdata;
    if (mem_en) mem_rdata <= mem[midx(mem_addr)];
  end

  function automatic logic [31:0] word(input logic [7:0] rd, wr, pv,
                                       input logic sec, priv, en);
    return {5'b0, en, priv, sec, pv, wr, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] cid, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cid = cid; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic access(input logic [1:0] k, input logic [16:0] a, input logic s, p,
                        input logic [2:0] c, input logic [31:0] wd, input bit exp,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_sec = s; req_priv = p;
    req_cid = c; req_wdata = wd;
    #1;
    chk(req_grant == exp, tag, 32'(req_grant), 32'(exp));
    chk(mem_en == exp, {tag, " mem_en"}, 32'(mem_en), 32'(exp));
    @(posedge clk);
    #1;
    chk(illegal_o == !exp, {tag, " illegal"}, 32'(illegal_o), 32'(!exp));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_data(input logic [16:0] a, input logic [2:0] c, input bit exp,
                           input logic [31:0] exp_d, input string tag);
    access(2'd0, a, 1'b1, 1'b1, c, 32'h0, exp, tag);
    chk(req_rdata == exp_d, {tag, " rdata"}, req_rdata, exp_d);
  endtask

  task automatic t_reset;
    cfg_read(6'd0, 32'h0, "R2 page0 word after reset");
    cfg_read(6'd32, 32'h0, "R2 control after reset");
    cfg_read(6'd33, 32'h0, "R11 fault status after reset");
    chk(illegal_o == 1'b0, "R2 illegal after reset", 32'(illegal_o), 32'h0);
  endtask

  task automatic t_default;
    access(2'd1, 17'h03010, 1'b1, 1'b0, 3'd1, 32'h0, 1'b1, "R2 trusted unpriv write");
    access(2'd0, 17'h03010, 1'b1, 1'b1, 3'd1, 32'h0, 1'b1, "R2 trusted priv read");
    access(2'd0, 17'h03010, 1'b1, 1'b1, 3'd2, 32'h0, 1'b0, "R2 other CID read");
    access(2'd0, 17'h03010, 1'b0, 1'b1, 3'd1, 32'h0, 1'b0, "R5 nonsecure to default page");
  endtask

  task automatic t_cfg_guard;
    cfg_write(3'd2, 6'd5, word(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1));
    cfg_read(6'd5, 32'h0, "R3 untrusted page write ignored");
    cfg_write(3'd3, 6'd32, 32'h1);
    cfg_read(6'd32, 32'h0, "R3 untrusted control write ignored");
    access(2'd0, 17'h05000, 1'b0, 1'b0, 3'd2, 32'h0, 1'b0, "R3 page5 still default");
    cfg_write(3'd1, 6'd5, 32'h0000_1234);
    cfg_read(6'd5, 32'h0000_1234, "R3 trusted write lands");
  endtask

  task automatic t_enable;
    cfg_write(3'd1, 6'd6, word(8'h04, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0));
    access(2'd0, 17'h06000, 1'b0, 1'b0, 3'd2, 32'h0, 1'b0, "R4 disabled word ignored");
    cfg_write(3'd1, 6'd6, word(8'h04, 8'h04, 8'h04, 1'b0, 1'b0, 1'b1));
    access(2'd0, 17'h06000, 1'b0, 1'b0, 3'd2, 32'h0, 1'b1, "R4 enabled word applies");
  endtask

  task automatic t_bitmaps;
    cfg_write(3'd1, 6'd7, word(8'h06, 8'h02, 8'h06, 1'b1, 1'b0, 1'b1));
    access(2'd0, 17'h07000, 1'b1, 1'b1, 3'd2, 32'h0, 1'b1, "R6 CID2 read granted");
    access(2'd1, 17'h07000, 1'b1, 1'b1, 3'd2, 32'h0, 1'b0, "R6 CID2 write refused");
    access(2'd1, 17'h07000, 1'b1, 1'b1, 3'd1, 32'h0, 1'b1, "R6 CID1 write granted");
    access(2'd0, 17'h07000, 1'b1, 1'b1, 3'd3, 32'h0, 1'b0, "R6 CID3 read refused");
    access(2'd3, 17'h07000, 1'b1, 1'b1, 3'd1, 32'h0, 1'b0, "R6 reserved kind refused");
  endtask

  task automatic t_priv;
    cfg_write(3'd1, 6'd8, word(8'h06, 8'h06, 8'h02, 1'b1, 1'b1, 1'b1));
    access(2'd0, 17'h08000, 1'b1, 1'b0, 3'd1, 32'h0, 1'b0, "R7 unpriv on priv page");
    access(2'd0, 17'h08000, 1'b1, 1'b1, 3'd1, 32'h0, 1'b1, "R7 priv with bitmap");
    access(2'd0, 17'h08000, 1'b1, 1'b1, 3'd2, 32'h0, 1'b0, "R7 priv without bitmap");
  endtask

  task automatic t_bypass;
    cfg_write(3'd1, 6'd9, word(8'h02, 8'h02, 8'h02, 1'b0, 1'b0, 1'b1));
    access(2'd0, 17'h09000, 1'b1, 1'b0, 3'd1, 32'h0, 1'b0, "R8 secure read no bypass");
    access(2'd2, 17'h09000, 1'b0, 1'b0, 3'd1, 32'h0, 1'b1, "R9 nonsecure exec ok");
    cfg_write(3'd1, 6'd32, 32'h1);
    cfg_read(6'd32, 32'h1, "R8 bypass readback");
    access(2'd0, 17'h09000, 1'b1, 1'b0, 3'd1, 32'h0, 1'b1, "R8 secure read bypass");
    access(2'd1, 17'h09000, 1'b1, 1'b0, 3'd1, 32'h0, 1'b1, "R8 secure write bypass");
    access(2'd2, 17'h09000, 1'b1, 1'b0, 3'd1, 32'h0, 1'b0, "R9 secure exec bypass");
  endtask

  task automatic t_data;
    access(2'd1, 17'h02040, 1'b1, 1'b1, 3'd1, 32'hCAFE_0001, 1'b1, "R10 granted write");
    access(2'd1, 17'h02040, 1'b1, 1'b1, 3'd4, 32'hDEAD_BEEF, 1'b0, "R10 refused write");
    read_data(17'h02040, 3'd1, 1'b1, 32'hCAFE_0001, "R10 data kept");
    read_data(17'h02040, 3'd4, 1'b0, 32'h0, "R10 refused read zero");
  endtask

  task automatic t_fault_and_pages;
    access(2'd0, 17'h0A123, 1'b1, 1'b1, 3'd5, 32'h0, 1'b0, "R11 refusal page10");
    #1;
    @(posedge clk); #1;
    chk(illegal_o == 1'b0, "R11 pulse one cycle", 32'(illegal_o), 32'h0);
    cfg_read(6'd33, 32'h0000_002A, "R11 fault page10");
    cfg_write(3'd1, 6'd31, word(8'h04, 8'h04, 8'h04, 1'b1, 1'b0, 1'b1));
    access(2'd0, 17'h1F000, 1'b1, 1'b1, 3'd2, 32'h0, 1'b1, "R1 first byte page31");
    access(2'd0, 17'h1FFFF, 1'b1, 1'b1, 3'd2, 32'h0, 1'b1, "R1 last byte page31");
    access(2'd0, 17'h1EFFF, 1'b1, 1'b1, 3'd2, 32'h0, 1'b0, "R1 last byte page30");
    cfg_read(6'd33, 32'h0000_003E, "R11 fault page30");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_sec = 1'b0;
    req_priv = 1'b0; req_cid = '0; req_wdata = '0; cfg_we = 1'b0; cfg_cid = '0;
    cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_default();
    t_cfg_guard();
    t_enable();
    t_bitmaps();
    t_priv();
    t_bypass();
    t_data();
    t_fault_and_pages();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule